// File: doc/BRIEF.md
# SHA-256 Compression Core with Rescheduled Rounds

This block runs the SHA-256 compression function over one 512-bit block. The caller streams the 64 already-expanded 32-bit schedule words, one per cycle, with the first word on the same cycle as `start`. The round constants are generated inside the core. Each round is split over two register stages. In the cycle that accepts W_t, the core forms the partial sum (future H) + K_t + W_t. In the next cycle it uses that sum to update the A and E words. Only A and E are computed; the other six state words are copies of their neighbours.

The eight 32-bit digest words sit in a bank that serves three purposes. It is the chaining value for the next block. It is a ring through which a custom initial value can be shifted in one word at a time. It is also the source of a narrow readout. Words 0 and 4 of the new digest are added into the final round. The other six are accumulated over four finishing cycles by one adder on the A side and one on the E side. After `done`, the digest appears on a 32-bit port one word per cycle. The bank ends the readout holding the digest, so a message made of several blocks is hashed by issuing `start` again.

Top module: `sha_rr_core`

## Requirements
- R1: After reset, the digest bank holds the standard SHA-256 initial hash (word 0 = 0x6a09e667 through word 7 = 0x5be0cd19), `digest_out` shows word 0 and `done` is low.
- R2: With `start` high, `w_in` must carry W_0; `w_in` must then carry W_1 through W_63 on the following 63 cycles. After 64 rounds and the feed-forward addition, the bank holds the compression result (for the one-block message "abc" this is ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad).
- R3: If `start` is sampled at clock edge 0, `done` is high in the cycle that follows edge 68 and low in every earlier cycle of the block.
- R4: In the `done` cycle `digest_out` carries digest word 0. Words 1 to 7 follow, one per cycle, in the next seven cycles.
- R5: After readout the bank still holds the digest. A following `start` uses it as the chaining value, so two back-to-back blocks of the 56-byte message "abcdbcde...nopq" give 248d6a61 d20638b8 e5c02693 0c3e6039 a33ce459 64ff2167 f6ecedd4 19db06c1.
- R6: While idle, each cycle with `iv_load` high and `start` low shifts the bank toward word 0 by one word and writes `iv_in` into word 7. After eight loads, the first word loaded is word 0. After three loads from the reset state, `digest_out` shows 0xa54ff53a.
- R7: `start` and `iv_load` are ignored while a block is being processed or read out.
- R8: The digest bank does not change during the 64 rounds, so `digest_out` keeps showing the previous word 0 until the finishing cycles.
- R9: `done` is high for exactly one cycle per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a block; `w_in` carries W_0 in this cycle |
| w_in | input | 32 | Expanded schedule word for the current round |
| iv_in | input | 32 | Initial-value word shifted into the digest ring |
| iv_load | input | 1 | Shift `iv_in` into the ring (idle only) |
| done | output | 1 | One-cycle pulse marking digest word 0 on `digest_out` |
| digest_out | output | 32 | Digest word currently at the head of the ring |

## Verification
Two functions can fall into the same cycle. The first is a new `start` or `iv_load` request arriving while the round pipeline is busy. The second is a chained block beginning on the first idle cycle after the readout ring has rotated back into place. The first case is provoked by pulsing `start` and `iv_load` together, with a garbage IV word, in the middle of the second block of a two-block message. The second case is provoked by issuing that second block's `start` on the first cycle the core can accept it. Both are judged by the final digest, which must match the known two-block value exactly. The same block is also run after shifting the intermediate chaining value in through the IV ring, and must give the same digest.

// File: rtl/sha_rr_pkg.sv
package sha_rr_pkg;

    localparam int WORD_W     = 32;
    localparam int ROUNDS     = 64;
    localparam int DG_WORDS   = 8;
    localparam int LANE_WORDS = DG_WORDS / 2;
    localparam int CNT_W      = $clog2(ROUNDS + 1);
    localparam int KIDX_W     = $clog2(ROUNDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DG_WORDS-1:0][WORD_W-1:0] digest_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } state_t;

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN, PH_READ} phase_t;
    typedef enum logic [1:0] {DG_HOLD, DG_LOAD, DG_ACC, DG_ROT} dg_mode_t;

    function automatic word_t ror(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return ror(x, 2) ^ ror(x, 13) ^ ror(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return ror(x, 6) ^ ror(x, 11) ^ ror(x, 25);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t iv_of(input int idx);
        case (idx)
            0: return 32'h6a09e667;
            1: return 32'hbb67ae85;
            2: return 32'h3c6ef372;
            3: return 32'ha54ff53a;
            4: return 32'h510e527f;
            5: return 32'h9b05688c;
            6: return 32'h1f83d9ab;
            default: return 32'h5be0cd19;
        endcase
    endfunction

    function automatic word_t k_of(input logic [KIDX_W-1:0] t);
        case (t)
            6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
            6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
            6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
            6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
            6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
            6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
            6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
            6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
            6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
            6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
            6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
            6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
            6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
            6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
            6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
            6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
            6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
        endcase
    endfunction

endpackage

// File: rtl/sha_rr_round.sv
module sha_rr_round
    import sha_rr_pkg::*;
(
    input  state_t st,
    input  logic   init,
    input  word_t  p_q,
    input  word_t  fold_a,
    input  word_t  fold_e,
    input  word_t  h_src,
    input  word_t  k_t,
    input  word_t  w_t,
    output word_t  a_nx,
    output word_t  e_nx,
    output word_t  p_nx
);

    state_t opr;
    word_t  pe;
    word_t  t1;

    // Stage one: future-H plus constant plus word, one round ahead.
    assign p_nx = h_src + k_t + w_t;

    // Zeroed operands on the load cycle make A and E take the fold words.
    always_comb begin
        opr = init ? '0 : st;
        pe  = init ? '0 : p_q;
        t1  = pe + big_sig1(opr.e) + choose(opr.e, opr.f, opr.g);
        a_nx = t1 + big_sig0(opr.a) + majority(opr.a, opr.b, opr.c) + fold_a;
        e_nx = opr.d + t1 + fold_e;
    end

    logic unused_h;
    assign unused_h = ^opr.h;

endmodule

// File: rtl/sha_rr_digest.sv
module sha_rr_digest
    import sha_rr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dg_mode_t mode,
    input  logic     first,
    input  word_t    iv_in,
    input  word_t    acc_a,
    input  word_t    acc_e,
    output digest_t  dg
);

    word_t sum_a;
    word_t sum_e;

    // The two feed-forward adders, one per lane.
    assign sum_a = first ? acc_a : dg[0] + acc_a;
    assign sum_e = first ? acc_e : dg[LANE_WORDS] + acc_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DG_WORDS; i++) dg[i] <= iv_of(i);
        end else begin
            case (mode)
                DG_LOAD: begin
                    for (int i = 0; i < DG_WORDS-1; i++) dg[i] <= dg[i+1];
                    dg[DG_WORDS-1] <= iv_in;
                end
                DG_ROT: begin
                    for (int i = 0; i < DG_WORDS-1; i++) dg[i] <= dg[i+1];
                    dg[DG_WORDS-1] <= dg[0];
                end
                DG_ACC: begin
                    for (int i = 0; i < LANE_WORDS-1; i++) begin
                        dg[i]              <= dg[i+1];
                        dg[LANE_WORDS + i] <= dg[LANE_WORDS + i + 1];
                    end
                    dg[LANE_WORDS-1] <= sum_a;
                    dg[DG_WORDS-1]   <= sum_e;
                end
                default: ;
            endcase
        end
    end

    // R6
    load_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == DG_LOAD) |=> (dg[DG_WORDS-1] == $past(iv_in)) && (dg[0] == $past(dg[1])));

    // R4
    ring_rot_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == DG_ROT) |=> (dg[DG_WORDS-1] == $past(dg[0])));

endmodule

// File: rtl/sha_rr_core.sv
module sha_rr_core
    import sha_rr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] w_in,
    input  logic [31:0] iv_in,
    input  logic        iv_load,
    output logic        done,
    output logic [31:0] digest_out
);

    phase_t            ph_q;
    logic [CNT_W-1:0]  cnt_q;
    state_t            st_q;
    word_t             p_q;
    digest_t           dg;
    dg_mode_t          dg_mode;

    logic  init;
    logic  last;
    word_t fold_a;
    word_t fold_e;
    word_t h_src;
    word_t a_nx;
    word_t e_nx;
    word_t p_nx;

    assign init   = (ph_q == PH_IDLE) && start;
    assign last   = (ph_q == PH_RUN) && (cnt_q == CNT_W'(ROUNDS));
    assign fold_a = (init || last) ? dg[0] : '0;
    assign fold_e = (init || last) ? dg[LANE_WORDS] : '0;
    assign h_src  = (ph_q == PH_IDLE) ? dg[DG_WORDS-1] : st_q.g;

    always_comb begin
        case (ph_q)
            PH_IDLE: dg_mode = (!start && iv_load) ? DG_LOAD : DG_HOLD;
            PH_FIN:  dg_mode = DG_ACC;
            PH_READ: dg_mode = DG_ROT;
            default: dg_mode = DG_HOLD;
        endcase
    end

    sha_rr_round u_round (
        .st     (st_q),
        .init   (init),
        .p_q    (p_q),
        .fold_a (fold_a),
        .fold_e (fold_e),
        .h_src  (h_src),
        .k_t    (k_of(cnt_q[KIDX_W-1:0])),
        .w_t    (w_in),
        .a_nx   (a_nx),
        .e_nx   (e_nx),
        .p_nx   (p_nx)
    );

    sha_rr_digest u_digest (
        .clk   (clk),
        .rst   (rst),
        .mode  (dg_mode),
        .first (cnt_q == '0),
        .iv_in (iv_in),
        .acc_a (st_q.a),
        .acc_e (st_q.e),
        .dg    (dg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            st_q  <= '0;
            p_q   <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    st_q  <= '{a: a_nx, b: dg[1], c: dg[2], d: dg[3],
                               e: e_nx, f: dg[5], g: dg[6], h: dg[7]};
                    p_q   <= p_nx;
                    cnt_q <= CNT_W'(1);
                    ph_q  <= PH_RUN;
                end
                PH_RUN: begin
                    st_q <= '{a: a_nx, b: st_q.a, c: st_q.b, d: st_q.c,
                              e: e_nx, f: st_q.e, g: st_q.f, h: st_q.g};
                    p_q  <= p_nx;
                    if (last) begin
                        cnt_q <= '0;
                        ph_q  <= PH_FIN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FIN: begin
                    st_q <= '{a: st_q.b, b: st_q.c, c: st_q.d, d: '0,
                              e: st_q.f, f: st_q.g, g: st_q.h, h: '0};
                    if (cnt_q == CNT_W'(LANE_WORDS-1)) begin
                        cnt_q <= '0;
                        ph_q  <= PH_READ;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == CNT_W'(DG_WORDS-1)) begin
                        cnt_q <= '0;
                        ph_q  <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign done       = (ph_q == PH_READ) && (cnt_q == '0);
    assign digest_out = dg[0];

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ph_q == PH_FIN));

    // R8
    dg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RUN) |=> $stable(dg));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RUN && !last) |=> (ph_q == PH_RUN));

    // R2
    round_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RUN) |-> (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(ROUNDS)));

endmodule

// File: tb/sha_rr_core_bench.sv
`timescale 1ns/1ps
module sha_rr_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] w_in = '0;
    logic [31:0] iv_in = '0;
    logic        iv_load = 1'b0;
    logic        done;
    logic [31:0] digest_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] msg [16];
    logic [31:0] sched [64];
    logic [31:0] got [8];
    logic [31:0] mid [8];

    always #10 clk = ~clk;

    sha_rr_core u_sha_rr_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .w_in       (w_in),
        .iv_in      (iv_in),
        .iv_load    (iv_load),
        .done       (done),
        .digest_out (digest_out)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expand();
        for (int t = 0; t < 16; t++) sched[t] = msg[t];
        for (int t = 16; t < 64; t++) begin
            sched[t] = (rr(sched[t-2], 17) ^ rr(sched[t-2], 19) ^ (sched[t-2] >> 10))
                     + sched[t-7]
                     + (rr(sched[t-15], 7) ^ rr(sched[t-15], 18) ^ (sched[t-15] >> 3))
                     + sched[t-16];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; iv_load = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Stream one block; n counts edges after the start edge.
    task automatic run_block(input bit poke, input logic [31:0] hold0);
        @(negedge clk);
        start = 1'b1;
        w_in  = sched[0];
        for (int n = 0; n < 76; n++) begin
            @(negedge clk);
            start   = 1'b0;
            iv_load = 1'b0;
            w_in    = (n < 63) ? sched[n+1] : 32'h0;
            if (poke && n == 10) begin
                start   = 1'b1;
                iv_load = 1'b1;
                iv_in   = 32'hdeadbeef;
            end
            if (n == 30) chk("R8 digest held during rounds", digest_out, hold0);
            if (n == 67) chk("R3 done low before edge 68", {31'b0, done}, 32'h0);
            if (n == 68) chk("R3 done high after edge 68", {31'b0, done}, 32'h1);
            if (n == 69) chk("R9 done single cycle", {31'b0, done}, 32'h0);
            if (n >= 68) got[n-68] = digest_out;
        end
    endtask

    task automatic load_two_block_first();
        for (int k = 0; k < 14; k++)
            msg[k] = {8'(97+k), 8'(98+k), 8'(99+k), 8'(100+k)};
        msg[14] = 32'h80000000;
        msg[15] = 32'h0;
        expand();
    endtask

    task automatic load_two_block_second();
        for (int k = 0; k < 15; k++) msg[k] = 32'h0;
        msg[15] = 32'h000001c0;
        expand();
    endtask

    task automatic check_two_block(input string req);
        logic [31:0] exp [8];
        exp = '{32'h248d6a61, 32'hd20638b8, 32'he5c02693, 32'h0c3e6039,
                32'ha33ce459, 32'h64ff2167, 32'hf6ecedd4, 32'h19db06c1};
        for (int i = 0; i < 8; i++) chk(req, got[i], exp[i]);
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 reset digest word 0", digest_out, 32'h6a09e667);
        chk("R1 reset done low", {31'b0, done}, 32'h0);
    endtask

    task automatic test_abc();
        logic [31:0] exp [8];
        exp = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
        for (int k = 0; k < 16; k++) msg[k] = 32'h0;
        msg[0]  = 32'h61626380;
        msg[15] = 32'h00000018;
        expand();
        run_block(1'b0, 32'h6a09e667);
        // R2 result, R4 word order on the narrow port
        for (int i = 0; i < 8; i++) chk("R2 R4 abc digest word", got[i], exp[i]);
    endtask

    task automatic test_chain();
        do_reset();
        load_two_block_first();
        run_block(1'b0, 32'h6a09e667);
        for (int i = 0; i < 8; i++) mid[i] = got[i];
        load_two_block_second();
        // R7: start and iv_load poked mid-run must be ignored
        run_block(1'b1, mid[0]);
        check_two_block("R5 R7 chained two-block digest");
    endtask

    task automatic test_ivload();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 3) chk("R6 ring head after three loads", digest_out, 32'ha54ff53a);
            iv_load = 1'b1;
            iv_in   = mid[i];
        end
        @(negedge clk);
        iv_load = 1'b0;
        chk("R6 first loaded word at head", digest_out, mid[0]);
        load_two_block_second();
        run_block(1'b0, mid[0]);
        check_two_block("R6 digest from loaded IV");
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_abc();
        test_chain();
        test_ivload();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule